// File: doc/BRIEF.md
# Conditional Execution Gate

This block decides, in pure combinational logic, whether a 32-bit fixed-length instruction may run. Its inputs are the instruction's 4-bit predicate selector, the current 4-bit arithmetic status (negative, zero, carry, overflow) and the instruction's 4-bit class field. Selectors 0 to 14 are ordinary predicates over the status bits. Selector 15 opens a separate unconditional encoding space. For that selector the status is not consulted, and the class field alone decides execution.

Three results are produced. The first is the execute enable. The second is a flag raised only for the selector-15 space, so that a downstream decoder can route those encodings. The third is an 8-bit verdict byte matching a 256-entry lookup. A build parameter selects the internal form: a computed lookup table or direct per-predicate gates. Both forms give identical results at the ports. Compressed 16-bit instruction state is outside this block; the caller treats it as always unconditional.

Top module: `ccx_cond_eval`

## Requirements
- R1: Selectors 0 to 7 each test one status bit (status input bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V): 0 passes when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when N=1, 5 when N=0, 6 when V=1, 7 when V=0.
- R2: Selector 8 passes when C=1 and Z=0; selector 9 passes when C=0 or Z=1.
- R3: Selector 10 passes when N equals V; selector 11 passes when they differ.
- R4: Selector 12 passes when Z=0 and N equals V; selector 13 passes when Z=1 or N differs from V.
- R5: Selector 14 passes for every status value.
- R6: For selectors 0 to 14 the verdict byte is 0xFF when the predicate passes and 0x00 when it fails, equal to entry {status,selector} (status in the upper nibble of the 8-bit index) of the lookup; the execute enable equals the pass result.
- R7: For selector 15 the verdict byte is 0x20, the unconditional-space flag is 1, and the execute enable is 1 exactly when the class field equals 0x5 (the default class parameter).
- R8: For selectors 0 to 14 the unconditional-space flag is 0 and the class field has no effect on any output.
- R9: For selector 15 the status input has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cond_i | input | 4 | Predicate selector of the instruction |
| flags_i | input | 4 | Status bits, N in bit 3, Z in bit 2, C in bit 1, V in bit 0 |
| class_i | input | 4 | Instruction class field, used only for selector 15 |
| exec_o | output | 1 | Execute enable |
| uncond_o | output | 1 | High when the selector addresses the unconditional space |
| code_o | output | 8 | Verdict byte: 0xFF pass, 0x00 fail, 0x20 unconditional space |

## Verification
The block holds no state, so any fault shows on the ports during the same evaluation as the inputs that trigger it. A wrong table entry or a wrong predicate equation affects only one status/selector pair. For that reason every one of the 256 pairs is applied and compared against closed-form equations. A fault in the selector-15 routing shows up as a verdict byte other than 0x20, or as an enable that follows the status input or the wrong class. To expose such faults, the class field is swept under several status values, and it is also varied across the ordinary selectors.

// File: rtl/ccx_pkg.sv
package ccx_pkg;

  localparam int unsigned FIELD_W   = 4;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned NUM_SEL   = 1 << FIELD_W;
  localparam int unsigned TABLE_LEN = NUM_SEL * NUM_SEL;
  localparam int unsigned IDX_W     = 2 * FIELD_W;

  localparam logic [CODE_W-1:0] CODE_PASS    = 8'hFF;
  localparam logic [CODE_W-1:0] CODE_FAIL    = 8'h00;
  localparam logic [CODE_W-1:0] CODE_SPECIAL = 8'h20;

  localparam logic [FIELD_W-1:0] SEL_ALWAYS  = 4'd14;
  localparam logic [FIELD_W-1:0] SEL_SPECIAL = 4'd15;

  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } status_t;

  // Table entry computed pairwise: even selectors hold the base predicate,
  // odd selectors hold its complement.
  function automatic logic [CODE_W-1:0] entry_code(input logic [IDX_W-1:0] idx);
    status_t            st;
    logic [FIELD_W-1:0] sel;
    logic               base;
    logic               hit;
    st   = status_t'(idx[IDX_W-1:FIELD_W]);
    sel  = idx[FIELD_W-1:0];
    base = 1'b0;
    unique case (sel[3:1])
      3'd0: base = st.zero;
      3'd1: base = st.carry;
      3'd2: base = st.neg;
      3'd3: base = st.ovf;
      3'd4: base = st.carry & ~st.zero;
      3'd5: base = ~(st.neg ^ st.ovf);
      3'd6: base = ~st.zero & ~(st.neg ^ st.ovf);
      default: base = 1'b1;
    endcase
    hit = base ^ sel[0];
    if (sel == SEL_SPECIAL) begin
      entry_code = CODE_SPECIAL;
    end else if (sel == SEL_ALWAYS) begin
      entry_code = CODE_PASS;
    end else begin
      entry_code = hit ? CODE_PASS : CODE_FAIL;
    end
  endfunction

endpackage

// File: rtl/ccx_code_table.sv
module ccx_code_table
  import ccx_pkg::*;
(
  input  logic [FIELD_W-1:0] sel_i,
  input  logic [FIELD_W-1:0] status_i,
  output logic [CODE_W-1:0]  code_o
);

  logic [CODE_W-1:0] rom [TABLE_LEN];

  for (genvar gi = 0; gi < TABLE_LEN; gi++) begin : g_entry
    localparam logic [IDX_W-1:0]  IDX   = IDX_W'(gi);
    localparam logic [CODE_W-1:0] ENTRY = entry_code(IDX);
    assign rom[gi] = ENTRY;
  end

  logic [IDX_W-1:0] index;
  assign index  = {status_i, sel_i};
  assign code_o = rom[index];

endmodule

// File: rtl/ccx_flag_eval.sv
module ccx_flag_eval
  import ccx_pkg::*;
(
  input  logic [FIELD_W-1:0] sel_i,
  input  logic [FIELD_W-1:0] status_i,
  output logic [CODE_W-1:0]  code_o
);

  status_t            st;
  logic [NUM_SEL-1:0] pass_vec;
  logic               n_eq_v;

  assign st     = status_t'(status_i);
  assign n_eq_v = (st.neg == st.ovf);

  assign pass_vec[0]  =  st.zero;
  assign pass_vec[1]  = !st.zero;
  assign pass_vec[2]  =  st.carry;
  assign pass_vec[3]  = !st.carry;
  assign pass_vec[4]  =  st.neg;
  assign pass_vec[5]  = !st.neg;
  assign pass_vec[6]  =  st.ovf;
  assign pass_vec[7]  = !st.ovf;
  assign pass_vec[8]  =  st.carry && !st.zero;
  assign pass_vec[9]  =  st.zero || !st.carry;
  assign pass_vec[10] =  n_eq_v;
  assign pass_vec[11] = !n_eq_v;
  assign pass_vec[12] = !st.zero && n_eq_v;
  assign pass_vec[13] =  st.zero || !n_eq_v;
  assign pass_vec[14] =  1'b1;
  assign pass_vec[15] =  1'b0;

  always_comb begin
    if (sel_i == SEL_SPECIAL) begin
      code_o = CODE_SPECIAL;
    end else if (pass_vec[sel_i]) begin
      code_o = CODE_PASS;
    end else begin
      code_o = CODE_FAIL;
    end
  end

endmodule

// File: rtl/ccx_uncond_gate.sv
module ccx_uncond_gate
  import ccx_pkg::*;
#(
  parameter logic [FIELD_W-1:0] UNCOND_CLASS = 4'h5,
  parameter bit                 UNCOND_EN    = 1'b1
) (
  input  logic [FIELD_W-1:0] sel_i,
  input  logic [FIELD_W-1:0] class_i,
  output logic               special_o,
  output logic               special_run_o
);

  assign special_o = (sel_i == SEL_SPECIAL);

  if (UNCOND_EN) begin : g_class_check
    assign special_run_o = special_o && (class_i == UNCOND_CLASS);
  end else begin : g_never
    logic unused_class;
    assign unused_class  = ^class_i;
    assign special_run_o = 1'b0 & unused_class;
  end

endmodule

// File: rtl/ccx_cond_eval.sv
module ccx_cond_eval
  import ccx_pkg::*;
#(
  parameter bit                 USE_TABLE    = 1'b1,
  parameter logic [FIELD_W-1:0] UNCOND_CLASS = 4'h5,
  parameter bit                 UNCOND_EN    = 1'b1
) (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  input  logic [3:0] class_i,
  output logic       exec_o,
  output logic       uncond_o,
  output logic [7:0] code_o
);

  logic [CODE_W-1:0] verdict;
  logic              special;
  logic              special_run;

  if (USE_TABLE) begin : g_table
    ccx_code_table u_table (
      .sel_i    (cond_i),
      .status_i (flags_i),
      .code_o   (verdict)
    );
  end else begin : g_gates
    ccx_flag_eval u_gates (
      .sel_i    (cond_i),
      .status_i (flags_i),
      .code_o   (verdict)
    );
  end

  ccx_uncond_gate #(
    .UNCOND_CLASS (UNCOND_CLASS),
    .UNCOND_EN    (UNCOND_EN)
  ) u_uncond (
    .sel_i         (cond_i),
    .class_i       (class_i),
    .special_o     (special),
    .special_run_o (special_run)
  );

  assign exec_o   = special ? special_run : (verdict == CODE_PASS);
  assign uncond_o = special;
  assign code_o   = verdict;

endmodule

// File: rtl/ccx_cond_eval_chk.sv
module ccx_cond_eval_chk (
  input logic [3:0] cond_i,
  input logic [3:0] flags_i,
  input logic [3:0] class_i,
  input logic       exec_o,
  input logic       uncond_o,
  input logic [7:0] code_o
);

  always_comb begin
    if (cond_i == 4'd0) begin
      a_r1_zero_test: assert (exec_o == flags_i[2]);
    end
    if (cond_i == 4'd8) begin
      a_r2_higher: assert (exec_o == (flags_i[1] && !flags_i[2]));
    end
    if (cond_i == 4'd10) begin
      a_r3_ge: assert (exec_o == (flags_i[3] == flags_i[0]));
    end
    if (cond_i == 4'd12) begin
      a_r4_gt: assert (exec_o == (!flags_i[2] && (flags_i[3] == flags_i[0])));
    end
    if (cond_i == 4'd14) begin
      a_r5_always_runs: assert (exec_o && code_o == 8'hFF);
    end
    if (cond_i != 4'd15) begin
      a_r6_code_legal: assert (code_o == 8'hFF || code_o == 8'h00);
      a_r6_code_vs_exec: assert ((code_o == 8'hFF) == exec_o);
      a_r8_no_special: assert (!uncond_o);
    end else begin
      a_r7_special_code: assert (uncond_o && code_o == 8'h20);
      a_r7_class_rule: assert (exec_o == (class_i == 4'h5));
    end
  end

endmodule

bind ccx_cond_eval ccx_cond_eval_chk chk_i (
  .cond_i   (cond_i),
  .flags_i  (flags_i),
  .class_i  (class_i),
  .exec_o   (exec_o),
  .uncond_o (uncond_o),
  .code_o   (code_o)
);

// File: tb/ccx_cond_eval_tb_top.sv
module ccx_cond_eval_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  typedef struct {
    logic [3:0] c;
    logic [3:0] f;
    logic [3:0] k;
    logic       e_exec;
    logic       e_unc;
    logic [7:0] e_code;
  } item_t;

  logic       clk;
  logic       rst_n;
  logic [3:0] cond_i;
  logic [3:0] flags_i;
  logic [3:0] class_i;
  logic       exec_o;
  logic       uncond_o;
  logic [7:0] code_o;

  int    checks;
  int    errors;
  bit    done;
  item_t q[$];

  ccx_cond_eval dut_i (
    .cond_i   (cond_i),
    .flags_i  (flags_i),
    .class_i  (class_i),
    .exec_o   (exec_o),
    .uncond_o (uncond_o),
    .code_o   (code_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic model_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy & !z;
      4'd9:  return !cy | z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z & (n == v);
      4'd13: return z | (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    if (c <= 4'd7)  return "R1/R6/R8";
    if (c <= 4'd9)  return "R2/R6/R8";
    if (c <= 4'd11) return "R3/R6/R8";
    if (c <= 4'd13) return "R4/R6/R8";
    if (c == 4'd14) return "R5/R6/R8";
    return "R7/R9";
  endfunction

  task automatic apply(input logic [3:0] c, input logic [3:0] f, input logic [3:0] k);
    item_t it;
    @(posedge clk);
    cond_i  = c;
    flags_i = f;
    class_i = k;
    it.c = c; it.f = f; it.k = k;
    if (c == 4'd15) begin
      it.e_exec = (k == 4'h5);
      it.e_unc  = 1'b1;
      it.e_code = 8'h20;
    end else begin
      it.e_exec = model_pass(c, f);
      it.e_unc  = 1'b0;
      it.e_code = it.e_exec ? 8'hFF : 8'h00;
    end
    q.push_back(it);
  endtask

  // Monitor: compares at the falling edge, half a period after inputs settle
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (exec_o !== it.e_exec || uncond_o !== it.e_unc || code_o !== it.e_code) begin
        errors++;
        $display("FAIL %s cond=%0d flags=%h class=%h: got exec=%b unc=%b code=%h, expected exec=%b unc=%b code=%h",
                 tag_of(it.c), it.c, it.f, it.k, exec_o, uncond_o, code_o,
                 it.e_exec, it.e_unc, it.e_code);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion within %0d cycles", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    cond_i  = 4'd0;
    flags_i = 4'd0;
    class_i = 4'd0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs, EQ with Z clear fails (R1, R6)
    apply(4'd0, 4'd0, 4'd0);

    // Full 256-entry sweep, class varied on ordinary selectors (R1..R6, R8)
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        apply(4'(c), 4'(f), 4'((f * 3 + c) & 15));
      end
    end

    // R8: class swept with fixed selector/status
    for (int k = 0; k < 16; k++) begin
      apply(4'd9, 4'b0110, 4'(k));
      apply(4'd12, 4'b1001, 4'(k));
    end

    // R7 and R9: selector 15, every class under several status values
    for (int f = 0; f < 16; f += 5) begin
      for (int k = 0; k < 16; k++) begin
        apply(4'd15, 4'(f), 4'(k));
      end
    end

    // R5: always-pass selector under every status value
    for (int f = 0; f < 16; f++) begin
      apply(4'd14, 4'(f), 4'hF);
    end

    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule